// File: doc/BRIEF.md
# Dual-Strobe Reversible Counter

This block is a 4-bit binary counter with two count strobes instead of a direction bit. A rising edge on the increment strobe adds one. A rising edge on the decrement strobe subtracts one. An edge on either strobe counts only while the other strobe is steady high. A free-running system clock samples both strobes, so every register in the block sits on that one clock. An active-low preset copies a parallel value into the counter. An active-high clear zeroes it and wins over everything else.

Two active-low outputs support chaining. The carry output goes low while the count is at its maximum and the increment strobe is low. The borrow output goes low while the count is zero and the decrement strobe is low. Both outputs are combinational. A following instance takes carry on its increment strobe and borrow on its decrement strobe. It steps on the same system clock edge as the stage before it, because the carry or borrow line rises when the strobe of the first stage rises.

Top module: `dual_strobe_counter`

## Requirements
- R1: After reset, the count is 0. With both strobes high, carry_n and borrow_n are both 1.
- R2: A rising edge on up_strobe, with dn_strobe high in both the previous and the current sample, raises the count by one on the next system clock edge.
- R3: A rising edge on dn_strobe, with up_strobe high in both the previous and the current sample, lowers the count by one on the next system clock edge.
- R4: The count wraps modulo 2^WIDTH: an increment from 15 gives 0, and a decrement from 0 gives 15.
- R5: A rising edge on one strobe while the other strobe is low does not change the count. When both strobes rise in the same sample, the count also does not change.
- R6: A strobe that stays at one level, or falls, does not change the count.
- R7: With preset_n low and clear low, the next clock edge loads preset_val. Strobe edges in that cycle are dropped.
- R8: With clear high, the next clock edge sets the count to 0, whatever preset_n and the strobes do.
- R9: borrow_n is 0 exactly when the count is 0 and dn_strobe is 0.
- R10: carry_n is 0 exactly when the count is 15 (all ones) and up_strobe is 0.
- R11: When carry_n drives the next stage's up_strobe and borrow_n drives its dn_strobe, two stages count as one 8-bit value. The upper stage steps on the same clock edge as the lower stage's wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_strobe | input | 1 | Increment strobe; counts on its rising edge |
| dn_strobe | input | 1 | Decrement strobe; counts on its rising edge |
| preset_n | input | 1 | Active-low parallel load request |
| clear | input | 1 | Active-high synchronous clear with top priority |
| preset_val | input | WIDTH | Value loaded while preset_n is low |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Low while the count is at its maximum and up_strobe is low |
| borrow_n | output | 1 | Low while the count is zero and dn_strobe is low |

## Verification
The hardest case to reach from the ports is the moment of a cascade transfer. Here the upper stage has to see a clean rising edge on its strobe in the very cycle that the lower stage wraps, and that edge comes only from the combinational carry or borrow of the lower stage. The bench chains two instances. It runs long increment and decrement sequences through every nibble boundary and through the full 8-bit wrap, and it compares the joint value with an arithmetic model after every step. A per-value sweep loads each low nibble and samples carry and borrow while the strobe is low. Directed sequences then lower one strobe, raise both together, and line up preset or clear with a strobe edge in the same cycle.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    STEP_HOLD  = 3'd0,
    STEP_CLEAR = 3'd1,
    STEP_LOAD  = 3'd2,
    STEP_UP    = 3'd3,
    STEP_DOWN  = 3'd4
  } step_e;
endpackage

// File: rtl/dsc_reset_sync.sv
module dsc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dsc_strobe_edge.sv
module dsc_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic up_strobe,
  input  logic dn_strobe,
  output logic up_hit,
  output logic dn_hit
);
  logic up_q, dn_q;
  logic up_d, dn_d;

  always_comb begin
    up_d = up_strobe;
    dn_d = dn_strobe;
  end

  // idle level of both strobes is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b1;
      dn_q <= 1'b1;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  // an edge counts only if the other strobe was and is high
  always_comb begin
    up_hit = up_strobe & ~up_q & dn_strobe & dn_q;
    dn_hit = dn_strobe & ~dn_q & up_strobe & up_q;
  end
endmodule

// File: rtl/dsc_step_steer.sv
module dsc_step_steer
  import dsc_pkg::*;
(
  input  logic  clear,
  input  logic  preset_n,
  input  logic  up_hit,
  input  logic  dn_hit,
  output step_e step
);
  always_comb begin
    step = STEP_HOLD;
    if (clear)          step = STEP_CLEAR;
    else if (!preset_n) step = STEP_LOAD;
    else if (up_hit)    step = STEP_UP;
    else if (dn_hit)    step = STEP_DOWN;
  end
endmodule

// File: rtl/dsc_count_core.sv
module dsc_count_core
  import dsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (step != STEP_HOLD);
    unique case (step)
      STEP_CLEAR: cnt_d = '0;
      STEP_LOAD:  cnt_d = load_val;
      STEP_UP:    cnt_d = cnt_q + ONE;
      STEP_DOWN:  cnt_d = cnt_q - ONE;
      default:    cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/dsc_cascade_out.sv
module dsc_cascade_out #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count,
  input  logic             up_strobe,
  input  logic             dn_strobe,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  always_comb begin
    carry_n  = ~((count == TOP) & ~up_strobe);
    borrow_n = ~((count == '0)  & ~dn_strobe);
  end
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_strobe,
  input  logic             dn_strobe,
  input  logic             preset_n,
  input  logic             clear,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  logic  rst_sync_n;
  logic  up_hit, dn_hit;
  step_e step;

  dsc_reset_sync #(.STAGES(SYNC_STAGES)) rst_i (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  dsc_strobe_edge edge_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .up_strobe (up_strobe),
    .dn_strobe (dn_strobe),
    .up_hit    (up_hit),
    .dn_hit    (dn_hit)
  );

  dsc_step_steer steer_i (
    .clear    (clear),
    .preset_n (preset_n),
    .up_hit   (up_hit),
    .dn_hit   (dn_hit),
    .step     (step)
  );

  dsc_count_core #(.WIDTH(WIDTH)) core_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step     (step),
    .load_val (preset_val),
    .count    (count)
  );

  dsc_cascade_out #(.WIDTH(WIDTH)) out_i (
    .count     (count),
    .up_strobe (up_strobe),
    .dn_strobe (dn_strobe),
    .carry_n   (carry_n),
    .borrow_n  (borrow_n)
  );
endmodule

// File: rtl/dual_strobe_counter_chk.sv
module dual_strobe_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_strobe,
  input logic             dn_strobe,
  input logic             preset_n,
  input logic             clear,
  input logic [WIDTH-1:0] preset_val,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && up_strobe && !$past(up_strobe) && dn_strobe && $past(dn_strobe) && !clear && preset_n)
    |=> (count == WIDTH'($past(count) + 1'b1)));

  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dn_strobe && !$past(dn_strobe) && up_strobe && $past(up_strobe) && !clear && preset_n)
    |=> (count == WIDTH'($past(count) - 1'b1)));

  p_no_dual_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && up_strobe && !$past(up_strobe) && dn_strobe && !$past(dn_strobe) && !clear && preset_n)
    |=> $stable(count));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clear && preset_n && !(up_strobe && !$past(up_strobe)) && !(dn_strobe && !$past(dn_strobe)))
    |=> $stable(count));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !preset_n) |=> (count == $past(preset_val)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));

  p_borrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!borrow_n) |-> (count == '0 && !dn_strobe));

  p_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry_n) |-> (count == {WIDTH{1'b1}} && !up_strobe));
endmodule

bind dual_strobe_counter dual_strobe_counter_chk #(.WIDTH(WIDTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .up_strobe  (up_strobe),
  .dn_strobe  (dn_strobe),
  .preset_n   (preset_n),
  .clear      (clear),
  .preset_val (preset_val),
  .count      (count),
  .carry_n    (carry_n),
  .borrow_n   (borrow_n)
);

// File: tb/dual_strobe_counter_tb_top.sv
module dual_strobe_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       up0, dn0, clr, pre_n;
  logic [3:0] pv0, pv1, q0, q1;
  logic       co0, bo0, co1, bo1;
  logic [7:0] ref8;
  int         n_checks = 0;
  int         n_fails  = 0;

  always #4 clk = ~clk;

  dual_strobe_counter dut_i (
    .clk(clk), .rst_n(rst_n), .up_strobe(up0), .dn_strobe(dn0),
    .preset_n(pre_n), .clear(clr), .preset_val(pv0),
    .count(q0), .carry_n(co0), .borrow_n(bo0));

  dual_strobe_counter stage1_i (
    .clk(clk), .rst_n(rst_n), .up_strobe(co0), .dn_strobe(bo0),
    .preset_n(pre_n), .clear(clr), .preset_val(pv1),
    .count(q1), .carry_n(co1), .borrow_n(bo1));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check8(input string req);
    check(req, {q1, q0}, ref8);
  endtask

  task automatic step_up();
    @(negedge clk) up0 = 1'b0;
    @(negedge clk);
    check("R10 carry", co0, (ref8[3:0] == 4'hF) ? 0 : 1);
    check("R9 borrow idle", bo0, 1);
    up0 = 1'b1;
    ref8 = ref8 + 8'd1;
    @(negedge clk);
    check8("R2/R4/R11 up");
  endtask

  task automatic step_down();
    @(negedge clk) dn0 = 1'b0;
    @(negedge clk);
    check("R9 borrow", bo0, (ref8[3:0] == 4'h0) ? 0 : 1);
    check("R10 carry idle", co0, 1);
    dn0 = 1'b1;
    ref8 = ref8 - 8'd1;
    @(negedge clk);
    check8("R3/R4/R11 down");
  endtask

  task automatic load8(input logic [7:0] v);
    @(negedge clk) begin pre_n = 1'b0; pv0 = v[3:0]; pv1 = v[7:4]; end
    @(negedge clk) pre_n = 1'b1;
    ref8 = v;
    check8("R7 load");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; up0 = 1'b1; dn0 = 1'b1; clr = 1'b0; pre_n = 1'b1;
    pv0 = '0; pv1 = '0; ref8 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check8("R1 count");
    check("R1 carry", co0, 1);
    check("R1 borrow", bo0, 1);

    // long runs through nibble boundaries and the 8-bit wrap
    for (int i = 0; i < 300; i++) step_up();
    for (int i = 0; i < 300; i++) step_down();

    // per-value sweep of the low nibble (carry and borrow levels)
    for (int v = 0; v < 16; v++) begin
      load8({4'h5, 4'(v)});
      step_up();
      step_down();
    end

    // R5 edge on one strobe while the other is low
    load8(8'h35);
    @(negedge clk) dn0 = 1'b0;
    @(negedge clk) up0 = 1'b0;
    @(negedge clk) up0 = 1'b1;
    @(negedge clk) check8("R5 gated up edge");
    dn0 = 1'b1;
    ref8 = ref8 - 8'd1;
    @(negedge clk) check8("R3 dn release counts");

    // R5 both strobes rise together
    @(negedge clk) begin up0 = 1'b0; dn0 = 1'b0; end
    @(negedge clk) begin up0 = 1'b1; dn0 = 1'b1; end
    @(negedge clk) check8("R5 dual rise");

    // R6 falling edge and steady levels
    @(negedge clk) up0 = 1'b0;
    @(negedge clk) check8("R6 falling edge");
    up0 = 1'b1;
    ref8 = ref8 + 8'd1;
    @(negedge clk) check8("R2 after fall");
    repeat (5) @(negedge clk);
    check8("R6 steady high");

    // R7 preset beats a strobe edge in the same cycle
    @(negedge clk) up0 = 1'b0;
    @(negedge clk) begin pre_n = 1'b0; pv0 = 4'h9; pv1 = 4'h7; up0 = 1'b1; end
    @(negedge clk) begin ref8 = 8'h79; check8("R7 load over edge"); pre_n = 1'b1; end
    @(negedge clk) check8("R7 edge dropped");

    // R8 clear beats preset and a strobe edge
    @(negedge clk) dn0 = 1'b0;
    @(negedge clk) begin clr = 1'b1; pre_n = 1'b0; pv0 = 4'hB; pv1 = 4'hA; dn0 = 1'b1; end
    @(negedge clk) begin ref8 = 8'h00; check8("R8 clear"); clr = 1'b0; pre_n = 1'b1; end
    @(negedge clk) check8("R8 clear held");
    check("R9 borrow dn high", bo0, 1);
    step_down();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule